// File: doc/BRIEF.md
# Block-Granular Write Window Guard

This block decides whether a program or erase request aimed at on-chip non-volatile memory may proceed. Software first writes two staging values, a lower bound and an upper bound, each counted in blocks (address bits above the block offset). A window-load strobe then copies both staged values into the persistent window store. The store is modelled here as flops. Two monitor outputs show the stored bounds at all times. A device that has never been loaded reads all ones in both monitors.

Each request carries an address and a flag saying whether the chip is rewriting itself under program control. Only those self-rewrite requests are restricted. A block is allowed when it is at or above the lower bound and strictly below the upper bound, so the upper bound names the first block past the window. With the default 1 KiB blocks, a window of blocks 0x1F9 to 0x1FB covers addresses 0x7E400 to 0x7EFFF and is stored with an upper bound of 0x1FC. Equal bounds leave the whole array open. An inverted pair, with the lower bound above the upper bound, is not a legal setting and locks every self-rewrite request.

The verdict appears one cycle after the request. Every refusal sets a sticky error flag that stays set until it is cleared.

Top module: `aw_gate`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `resp_valid`=0, `resp_permit`=0, `illegal_err`=0, and both `mon_start` and `mon_end` all ones (0x3FF at default width).
- R2: Writing a staging value (`stg_we`=1, `stg_sel`=0 for the lower bound, 1 for the upper bound) leaves `mon_start` and `mon_end` unchanged until a window load.
- R3: A cycle with `win_load`=1 makes `mon_start` equal the staged lower bound and `mon_end` equal the staged upper bound from the next cycle on. A staging write in that same cycle is not part of the load.
- R4: A request with `self_prog`=0 is always permitted, whatever the window holds.
- R5: When the stored bounds are equal, every request is permitted.
- R6: With lower < upper and `self_prog`=1, a request is permitted exactly when lower <= `req_addr`[19:10] < upper. The block equal to the upper bound is refused.
- R7: With lower > upper and `self_prog`=1, every request is refused.
- R8: A refused request sets `illegal_err` in the same cycle its response appears. The flag then holds until a cycle with `err_clr`=1 and no new refusal; if a refusal and `err_clr` fall in the same cycle, the flag stays set.
- R9: `resp_valid` is high exactly one cycle after each cycle with `req_valid`=1 and low otherwise. `resp_permit` is never high without `resp_valid`.
- R10: A request in the same cycle as `win_load` is judged against the window stored before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, restores the blank window |
| stg_we | input | 1 | Staging register write strobe |
| stg_sel | input | 1 | Staging target: 0 lower bound, 1 upper bound |
| stg_wdata | input | 10 | Block number to stage |
| win_load | input | 1 | Copy both staged bounds into the window store |
| req_valid | input | 1 | Program/erase request present |
| req_addr | input | 20 | Program/erase byte address |
| self_prog | input | 1 | Request comes from self-rewrite; only these are restricted |
| err_clr | input | 1 | Clear the sticky refusal flag |
| resp_valid | output | 1 | Verdict present for the request of the previous cycle |
| resp_permit | output | 1 | Verdict: request allowed |
| illegal_err | output | 1 | Sticky flag, set by any refusal |
| mon_start | output | 10 | Stored lower bound |
| mon_end | output | 10 | Stored upper bound (exclusive) |

## Verification
A wrong stored bound shows up on the monitor outputs in the cycle after the load. It also shows up in the first verdict near that bound, so the bench probes the blocks just below, at, and just above each bound. An off-by-one in the comparison appears only at the boundary blocks; a comparison swapped for the inverted case appears as a permit where a refusal is due. A flag that clears too early or too late differs at the ports in the very next cycle. The cycle-by-cycle reference model compares every output on every clock, so any such divergence is reported in the cycle it first appears.

// File: rtl/aw_pkg.sv
package aw_pkg;

    localparam int ADDR_W_DEF  = 20;
    localparam int BLK_LSB_DEF = 10;

    typedef enum logic [2:0] {
        V_FREE     = 3'd0,
        V_OPEN     = 3'd1,
        V_INSIDE   = 3'd2,
        V_OUTSIDE  = 3'd3,
        V_INVERTED = 3'd4
    } verdict_t;

    function automatic verdict_t classify(input logic        sp,
                                          input logic [31:0] lo,
                                          input logic [31:0] hi,
                                          input logic [31:0] blk);
        if (!sp)                    return V_FREE;
        if (lo == hi)               return V_OPEN;
        if (lo > hi)                return V_INVERTED;
        if (blk >= lo && blk < hi)  return V_INSIDE;
        return V_OUTSIDE;
    endfunction

    function automatic logic allows(input verdict_t v);
        return (v == V_FREE) || (v == V_OPEN) || (v == V_INSIDE);
    endfunction

endpackage

// File: rtl/aw_stage.sv
module aw_stage #(
    parameter int BLK_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             sel,
    input  logic [BLK_W-1:0] wdata,
    output logic [BLK_W-1:0] stage_lo,
    output logic [BLK_W-1:0] stage_hi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_lo <= '0;
            stage_hi <= '0;
        end else if (we) begin
            if (sel) stage_hi <= wdata;
            else     stage_lo <= wdata;
        end
    end
endmodule

// File: rtl/aw_store.sv
module aw_store #(
    parameter int BLK_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [BLK_W-1:0] new_lo,
    input  logic [BLK_W-1:0] new_hi,
    output logic [BLK_W-1:0] win_lo,
    output logic [BLK_W-1:0] win_hi
);
    // Reset stands for the erased, never-loaded state: all ones.
    always_ff @(posedge clk) begin
        if (rst) begin
            win_lo <= '1;
            win_hi <= '1;
        end else if (load) begin
            win_lo <= new_lo;
            win_hi <= new_hi;
        end
    end
endmodule

// File: rtl/aw_judge.sv
module aw_judge
    import aw_pkg::*;
#(
    parameter int BLK_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [BLK_W-1:0] req_blk,
    input  logic             self_prog,
    input  logic             err_clr,
    input  logic [BLK_W-1:0] win_lo,
    input  logic [BLK_W-1:0] win_hi,
    output logic             resp_valid,
    output logic             resp_permit,
    output logic             illegal_err
);
    verdict_t verdict;
    logic     ok;

    always_comb begin
        verdict = classify(self_prog, 32'(win_lo), 32'(win_hi), 32'(req_blk));
        ok      = allows(verdict);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid  <= 1'b0;
            resp_permit <= 1'b0;
            illegal_err <= 1'b0;
        end else begin
            resp_valid  <= req_valid;
            resp_permit <= req_valid && ok;
            if (req_valid && !ok)
                illegal_err <= 1'b1;
            else if (err_clr)
                illegal_err <= 1'b0;
        end
    end
endmodule

// File: rtl/aw_gate.sv
module aw_gate #(
    parameter int ADDR_W  = aw_pkg::ADDR_W_DEF,
    parameter int BLK_LSB = aw_pkg::BLK_LSB_DEF,
    localparam int BLK_W  = ADDR_W - BLK_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stg_we,
    input  logic              stg_sel,
    input  logic [BLK_W-1:0]  stg_wdata,
    input  logic              win_load,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              self_prog,
    input  logic              err_clr,
    output logic              resp_valid,
    output logic              resp_permit,
    output logic              illegal_err,
    output logic [BLK_W-1:0]  mon_start,
    output logic [BLK_W-1:0]  mon_end
);
    logic [BLK_W-1:0] stage_lo, stage_hi;
    logic [BLK_W-1:0] win_lo, win_hi;
    logic [BLK_W-1:0] req_blk;

    assign req_blk = req_addr[ADDR_W-1:BLK_LSB];

    aw_stage #(.BLK_W(BLK_W)) u_stage (
        .clk(clk), .rst(rst), .we(stg_we), .sel(stg_sel), .wdata(stg_wdata),
        .stage_lo(stage_lo), .stage_hi(stage_hi)
    );

    aw_store #(.BLK_W(BLK_W)) u_store (
        .clk(clk), .rst(rst), .load(win_load),
        .new_lo(stage_lo), .new_hi(stage_hi),
        .win_lo(win_lo), .win_hi(win_hi)
    );

    aw_judge #(.BLK_W(BLK_W)) u_judge (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_blk(req_blk),
        .self_prog(self_prog), .err_clr(err_clr),
        .win_lo(win_lo), .win_hi(win_hi),
        .resp_valid(resp_valid), .resp_permit(resp_permit),
        .illegal_err(illegal_err)
    );

    assign mon_start = win_lo;
    assign mon_end   = win_hi;
endmodule

// File: rtl/aw_gate_chk.sv
module aw_gate_chk #(
    parameter int ADDR_W  = 20,
    parameter int BLK_LSB = 10,
    localparam int BLK_W  = ADDR_W - BLK_LSB
) (
    input logic              clk,
    input logic              rst,
    input logic              stg_we,
    input logic              win_load,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              self_prog,
    input logic              err_clr,
    input logic              resp_valid,
    input logic              resp_permit,
    input logic              illegal_err,
    input logic [BLK_W-1:0]  mon_start,
    input logic [BLK_W-1:0]  mon_end,
    input logic [BLK_W-1:0]  stage_lo,
    input logic [BLK_W-1:0]  stage_hi
);
    logic [ADDR_W-1:0] blk_full;
    assign blk_full = req_addr >> BLK_LSB;

    // R1
    reset_blank_chk: assert property (@(posedge clk)
        rst |=> (!resp_valid && !resp_permit && !illegal_err &&
                 mon_start == '1 && mon_end == '1));

    // R2
    hold_window_chk: assert property (@(posedge clk) disable iff (rst)
        (!win_load || stg_we) |=> (!$past(win_load) ? ($stable(mon_start) && $stable(mon_end)) : 1'b1));

    // R3
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        win_load |=> (mon_start == $past(stage_lo) && mon_end == $past(stage_hi)));

    // R4
    free_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !self_prog) |=> resp_permit);

    // R6
    inside_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && self_prog && mon_start < mon_end &&
         ADDR_W'(mon_start) <= blk_full && blk_full < ADDR_W'(mon_end)) |=> resp_permit);

    // R7
    inverted_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && self_prog && mon_start > mon_end) |=> !resp_permit);

    // R8
    deny_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_permit) |-> illegal_err);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (illegal_err && !err_clr) |=> illegal_err);

    // R9
    resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    // R9
    no_stray_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);

    // R9
    permit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        resp_permit |-> resp_valid);
endmodule

bind aw_gate aw_gate_chk #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) u_chk (
    .clk(clk), .rst(rst), .stg_we(stg_we), .win_load(win_load),
    .req_valid(req_valid), .req_addr(req_addr), .self_prog(self_prog),
    .err_clr(err_clr), .resp_valid(resp_valid), .resp_permit(resp_permit),
    .illegal_err(illegal_err), .mon_start(mon_start), .mon_end(mon_end),
    .stage_lo(stage_lo), .stage_hi(stage_hi)
);

// File: tb/test_aw_gate.sv
`timescale 1ns/1ps
module test_aw_gate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stg_we = 1'b0, stg_sel = 1'b0;
    logic [9:0]  stg_wdata = '0;
    logic        win_load = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        self_prog = 1'b0;
    logic        err_clr = 1'b0;
    logic        resp_valid, resp_permit, illegal_err;
    logic [9:0]  mon_start, mon_end;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    aw_gate i_aw_gate (
        .clk(clk), .rst(rst), .stg_we(stg_we), .stg_sel(stg_sel),
        .stg_wdata(stg_wdata), .win_load(win_load), .req_valid(req_valid),
        .req_addr(req_addr), .self_prog(self_prog), .err_clr(err_clr),
        .resp_valid(resp_valid), .resp_permit(resp_permit),
        .illegal_err(illegal_err), .mon_start(mon_start), .mon_end(mon_end)
    );

    // Behavioural reference model
    int m_lo, m_hi, m_ws, m_we;
    bit m_rv, m_rp, m_err;
    int blk;
    bit ok;

    always @(posedge clk) begin
        if (rst) begin
            m_lo = 0; m_hi = 0; m_ws = 1023; m_we = 1023;
            m_rv = 0; m_rp = 0; m_err = 0;
        end else begin
            blk = int'(req_addr) / 1024;
            ok  = !self_prog || (m_ws == m_we) || (m_ws <= blk && blk < m_we);
            m_rv = req_valid;
            m_rp = req_valid && ok;
            if (req_valid && !ok) m_err = 1;
            else if (err_clr)     m_err = 0;
            if (win_load) begin m_ws = m_lo; m_we = m_hi; end
            if (stg_we) begin
                if (stg_sel) m_hi = int'(stg_wdata);
                else         m_lo = int'(stg_wdata);
            end
        end
    end

    task automatic expect_v(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare_model(input string tag);
        checks++;
        if (resp_valid !== m_rv || resp_permit !== m_rp || illegal_err !== m_err ||
            int'(mon_start) != m_ws || int'(mon_end) != m_we) begin
            fails++;
            $display("FAIL %s: actual v%0b p%0b e%0b s%0h e%0h expected v%0b p%0b e%0b s%0h e%0h",
                     tag, resp_valid, resp_permit, illegal_err, mon_start, mon_end,
                     m_rv, m_rp, m_err, m_ws, m_we);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        @(negedge clk);
        compare_model(tag);
        stg_we = 0; win_load = 0; req_valid = 0; err_clr = 0;
    endtask

    task automatic stage(input bit sel, input int v, input string tag);
        stg_we = 1; stg_sel = sel; stg_wdata = 10'(v);
        step(tag);
    endtask

    task automatic req(input int a, input bit sp, input string tag);
        req_valid = 1; req_addr = 20'(a); self_prog = sp;
        step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        step("R1");
        step("R1");
        rst = 0;
        @(negedge clk);
        // R1 reset state
        expect_v("R1 mon_start", mon_start, 'h3FF);
        expect_v("R1 mon_end", mon_end, 'h3FF);
        expect_v("R1 resp_valid", resp_valid, 0);
        expect_v("R1 illegal_err", illegal_err, 0);

        // R5 blank window (equal bounds) permits all
        req('h7F000, 1, "R5");
        expect_v("R5 open window", resp_permit, 1);
        // R9 idle cycle has no response
        step("R9");
        expect_v("R9 idle", resp_valid, 0);

        // R2 staging does not reach monitors
        stage(0, 'h1F9, "R2");
        stage(1, 'h1FC, "R2");
        expect_v("R2 mon_start", mon_start, 'h3FF);
        expect_v("R2 mon_end", mon_end, 'h3FF);

        // R3 load
        win_load = 1; step("R3");
        expect_v("R3 mon_start", mon_start, 'h1F9);
        expect_v("R3 mon_end", mon_end, 'h1FC);

        // R6 boundaries of window 0x1F9..0x1FB
        req('h7E400, 1, "R6"); expect_v("R6 first block", resp_permit, 1);
        req('h7EFFF, 1, "R6"); expect_v("R6 last byte", resp_permit, 1);
        expect_v("R8 no refusal yet", illegal_err, 0);
        req('h7F000, 1, "R6"); expect_v("R6 end bound refused", resp_permit, 0);
        // R8 flag set with the refusal, then sticky
        expect_v("R8 flag set", illegal_err, 1);
        step("R8"); expect_v("R8 flag held", illegal_err, 1);
        req('h7E3FF, 1, "R6"); expect_v("R6 below start refused", resp_permit, 0);
        err_clr = 1; step("R8"); expect_v("R8 cleared", illegal_err, 0);
        // R8 refusal and clear together: stays set
        err_clr = 1; req('h00000, 1, "R8"); expect_v("R8 set wins", illegal_err, 1);
        err_clr = 1; step("R8"); expect_v("R8 clear again", illegal_err, 0);

        // R4 not self-rewrite is unrestricted
        req('h7F000, 0, "R4"); expect_v("R4 boot permit", resp_permit, 1);
        expect_v("R4 no flag", illegal_err, 0);

        // R10 same-cycle load uses old window; R3 staging in load cycle excluded
        stage(0, 'h010, "R10");
        stage(1, 'h010, "R10");
        win_load = 1; stg_we = 1; stg_sel = 1; stg_wdata = 10'h020;
        req('h7F000, 1, "R10");
        expect_v("R10 old window refuses", resp_permit, 0);
        expect_v("R3 load excludes same-cycle write", mon_end, 'h010);
        req('h7F000, 1, "R5"); expect_v("R5 equal bounds permit", resp_permit, 1);
        err_clr = 1; step("R8");

        // R7 inverted bounds lock everything
        stage(0, 'h020, "R7");
        stage(1, 'h010, "R7");
        win_load = 1; step("R7");
        req('h05400, 1, "R7"); expect_v("R7 between", resp_permit, 0);
        req('h08000, 1, "R7"); expect_v("R7 at lower", resp_permit, 0);
        req('h04000, 1, "R7"); expect_v("R7 at upper", resp_permit, 0);
        req('h05400, 0, "R7"); expect_v("R7 free mode permit", resp_permit, 1);

        // back-to-back mixed stream, model compared each clock (R6, R9)
        stage(0, 'h002, "R6");
        stage(1, 'h005, "R6");
        win_load = 1; step("R6");
        for (int i = 0; i < 16; i++) begin
            req_valid = (i % 3) != 2; self_prog = (i % 5) != 0;
            req_addr = 20'(i * 'h200);
            err_clr = (i % 4) == 3;
            step("R9");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule